// File: doc/BRIEF.md
# Wait-State Bus Cycle Sequencer

This block runs one memory or I/O transfer at a time over a multiplexed bus whose low address byte and data byte share the same eight lines. A requester presents a 20-bit address, a direction flag, a memory/IO flag and a write byte. The sequencer then steps through a fixed four-state cycle. The first state announces the address with a latch strobe. The middle states carry the read or write command and the data-enable strobe. The last state returns every control line to its idle level and raises a one-clock completion pulse.

Slow devices stretch the cycle by holding the ready input low. The sequencer samples ready only at the close of the second state and at the close of each inserted wait state. One wait state is added for every low sample, so a device that answers late still gets a cycle of well-defined length. For reads, the byte on the shared lines is captured when the third state closes and is held on the read-data output until the next read.

The shared lines are modelled as an output byte, an output enable and a separate input byte. An external tristate pad merges them. Each bus state lasts one clock period.

Top module: `bus_cycle_seq`

## Requirements
- R1: While rst_ni is low, ale_o is 0, rd_no, wr_no, den_no and dtr_no are 1, ad_oe_o is 0 and done_o is 0, and no cycle starts.
- R2: With ready_i high at the close of the second state, a request accepted while idle runs exactly four clocks. The first state follows the accepting edge, and done_o is high in the fourth.
- R3: In the first state ale_o is 1, ad_oe_o is 1, ad_o equals the address bits [7:0] and a_hi_o equals the address bits [19:8]. ale_o is 0 in every other state.
- R4: From the first state through the fourth, dtr_no is 0 for a read and 1 for a write, iom_o is 1 for an I/O cycle and 0 for a memory cycle, and a_hi_o holds the address bits [19:8].
- R5: In the second state, in every wait state and in the third state, rd_no is 0 for a read or wr_no is 0 for a write, never both, and den_no is 0.
- R6: For a write, ad_oe_o is 1 and ad_o carries the write byte from the second state through the fourth. For a read, ad_oe_o is 0 in those states.
- R7: If ready_i is low at the close of the second state, a wait state follows. Each wait state samples ready_i again at its close, so N consecutive low samples add exactly N clocks.
- R8: For a read, rdata_o takes the value of ad_i at the close of the third state and keeps it until the next read captures a new byte.
- R9: In the fourth state rd_no, wr_no and den_no are 1 and done_o is 1 for exactly one clock.
- R10: req_i and the request fields are ignored during the first, second, wait and third states. A request held high during the fourth state starts a new first state on the next clock.
- R11: ready_i has no effect in the first, third and fourth states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one bus state per period |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Transfer request |
| addr_i | input | 20 | Transfer address |
| wr_i | input | 1 | 1 = write, 0 = read |
| io_i | input | 1 | 1 = I/O space, 0 = memory space |
| wdata_i | input | 8 | Write byte |
| ready_i | input | 1 | Device ready, low requests wait states |
| ad_i | input | 8 | Shared lines as seen from the pad |
| ad_o | output | 8 | Value driven onto the shared lines |
| ad_oe_o | output | 1 | Output enable for the shared lines |
| a_hi_o | output | 12 | Address bits [19:8] |
| ale_o | output | 1 | Address latch strobe, active high |
| rd_no | output | 1 | Read command, active low |
| wr_no | output | 1 | Write command, active low |
| dtr_no | output | 1 | Transfer direction, 1 = transmit, 0 = receive |
| den_no | output | 1 | Data transceiver enable, active low |
| iom_o | output | 1 | 1 = I/O cycle, 0 = memory cycle |
| rdata_o | output | 8 | Captured read byte |
| done_o | output | 1 | One-clock completion pulse |

## Verification
A state register that skips or repeats a state shows at once at the pins. The latch strobe would last more or less than one clock, the command strobe would run a clock too short or too long against the count of ready-low samples, or the completion pulse would appear in the wrong clock. Each of these is visible within the same cycle. A wrong direction or space bit shows on dtr_no and iom_o from the first state. A capture on the wrong edge shows as a stale or altered read byte, because the bench changes ad_i between the third and fourth states. Requests and address changes presented in mid-cycle would show as a stretched cycle or a changed high address before completion.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_T1   = 3'd1,
    S_T2   = 3'd2,
    S_TW   = 3'd3,
    S_T3   = 3'd4,
    S_T4   = 3'd5
  } bcs_state_e;
endpackage

// File: rtl/bcs_fsm.sv
module bcs_fsm
  import bcs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       ready_i,
  output bcs_state_e state_o,
  output logic       accept_o
);
  bcs_state_e state_q, state_d;

  assign accept_o = req_i && (state_q == S_IDLE || state_q == S_T4);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (req_i) state_d = S_T1;
      S_T1:    state_d = S_T2;
      S_T2:    state_d = ready_i ? S_T3 : S_TW;
      S_TW:    state_d = ready_i ? S_T3 : S_TW;
      S_T3:    state_d = S_T4;
      S_T4:    state_d = req_i ? S_T1 : S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/bcs_latch.sv
module bcs_latch
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  bcs_state_e        state_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              io_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] ad_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_o,
  output logic              io_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      wr_o    <= 1'b0;
      io_o    <= 1'b0;
      wdata_o <= '0;
    end else if (accept_i) begin
      addr_o  <= addr_i;
      wr_o    <= wr_i;
      io_o    <= io_i;
      wdata_o <= wdata_i;
    end
  end

  // read byte taken as T3 closes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      rdata_o <= '0;
    else if (state_i == S_T3 && !wr_o) rdata_o <= ad_i;
  end
endmodule

// File: rtl/bcs_pins.sv
module bcs_pins
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  bcs_state_e        state_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              io_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic [HI_W-1:0]   a_hi_o,
  output logic              ale_o,
  output logic              rd_no,
  output logic              wr_no,
  output logic              dtr_no,
  output logic              den_no,
  output logic              iom_o
);
  logic in_cyc, cmd_ph, data_ph;

  assign in_cyc  = state_i inside {S_T1, S_T2, S_TW, S_T3, S_T4};
  assign cmd_ph  = state_i inside {S_T2, S_TW, S_T3};
  assign data_ph = state_i inside {S_T2, S_TW, S_T3, S_T4};

  always_comb begin
    ale_o   = (state_i == S_T1);
    rd_no   = !(cmd_ph && !wr_i);
    wr_no   = !(cmd_ph && wr_i);
    den_no  = !cmd_ph;
    dtr_no  = in_cyc ? wr_i : 1'b1;
    iom_o   = in_cyc && io_i;
    a_hi_o  = in_cyc ? addr_i[ADDR_W-1:DATA_W] : '0;
    ad_oe_o = 1'b0;
    ad_o    = '0;
    if (state_i == S_T1) begin
      ad_oe_o = 1'b1;
      ad_o    = addr_i[DATA_W-1:0];
    end else if (data_ph && wr_i) begin
      ad_oe_o = 1'b1;
      ad_o    = wdata_i;
    end
  end
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              io_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ready_i,
  input  logic [DATA_W-1:0] ad_i,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic [HI_W-1:0]   a_hi_o,
  output logic              ale_o,
  output logic              rd_no,
  output logic              wr_no,
  output logic              dtr_no,
  output logic              den_no,
  output logic              iom_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o
);
  bcs_state_e        state;
  logic              accept;
  logic [ADDR_W-1:0] cur_addr;
  logic              cur_wr, cur_io;
  logic [DATA_W-1:0] cur_wdata;

  bcs_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .ready_i  (ready_i),
    .state_o  (state),
    .accept_o (accept)
  );

  bcs_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .state_i  (state),
    .addr_i   (addr_i),
    .wr_i     (wr_i),
    .io_i     (io_i),
    .wdata_i  (wdata_i),
    .ad_i     (ad_i),
    .addr_o   (cur_addr),
    .wr_o     (cur_wr),
    .io_o     (cur_io),
    .wdata_o  (cur_wdata),
    .rdata_o  (rdata_o)
  );

  bcs_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .state_i (state),
    .addr_i  (cur_addr),
    .wr_i    (cur_wr),
    .io_i    (cur_io),
    .wdata_i (cur_wdata),
    .ad_o    (ad_o),
    .ad_oe_o (ad_oe_o),
    .a_hi_o  (a_hi_o),
    .ale_o   (ale_o),
    .rd_no   (rd_no),
    .wr_no   (wr_no),
    .dtr_no  (dtr_no),
    .den_no  (den_no),
    .iom_o   (iom_o)
  );

  assign done_o = (state == S_T4);
endmodule

// File: rtl/bcs_chk.sv
module bcs_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ale_o,
  input logic              rd_no,
  input logic              wr_no,
  input logic              den_no,
  input logic              dtr_no,
  input logic              ad_oe_o,
  input logic              done_o,
  input logic [DATA_W-1:0] rdata_o
);
  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (!ale_o && rd_no && wr_no && den_no && dtr_no && !ad_oe_o && !done_o)); // R1

  AST_ALE_NO_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> (rd_no && wr_no && den_no)); // R3

  AST_ALE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !ale_o); // R3

  AST_ALE_THEN_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> (!rd_no || !wr_no)); // R5

  AST_ONE_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_no && !wr_no)); // R5

  AST_DEN_WITH_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_no || !wr_no) |-> !den_no); // R5

  AST_WRITE_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_no |-> ad_oe_o); // R6

  AST_READ_FLOATS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> !ad_oe_o); // R6

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9

  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (rd_no && wr_no && den_no)); // R9

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rdata_o) |-> $past(!rd_no)); // R8
endmodule

bind bus_cycle_seq bcs_chk #(.DATA_W(DATA_W)) u_bcs_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ale_o   (ale_o),
  .rd_no   (rd_no),
  .wr_no   (wr_no),
  .den_no  (den_no),
  .dtr_no  (dtr_no),
  .ad_oe_o (ad_oe_o),
  .done_o  (done_o),
  .rdata_o (rdata_o)
);

// File: tb/bus_cycle_seq_tb_top.sv
module bus_cycle_seq_tb_top;
  localparam int NV = 6;
  // {addr[41:22], wr[21], io[20], wdata[19:12], waits[11:8], rdev[7:0]}
  localparam logic [41:0] VEC [NV] = '{
    {20'hFFFF0, 1'b0, 1'b0, 8'h00, 4'd0, 8'hEA},
    {20'h12345, 1'b1, 1'b0, 8'hA5, 4'd0, 8'h00},
    {20'h00080, 1'b0, 1'b1, 8'h00, 4'd2, 8'h3C},
    {20'hABCDE, 1'b1, 1'b1, 8'h5A, 4'd3, 8'h00},
    {20'h80001, 1'b0, 1'b0, 8'h00, 4'd1, 8'hC3},
    {20'h7FFFF, 1'b1, 1'b0, 8'hFF, 4'd0, 8'h00}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [19:0] addr_i = '0;
  logic        wr_i = 1'b0, io_i = 1'b0;
  logic [7:0]  wdata_i = '0;
  logic        ready_i = 1'b1;
  logic [7:0]  ad_i = '0;
  logic [7:0]  ad_o, rdata_o;
  logic [11:0] a_hi_o;
  logic        ad_oe_o, ale_o, rd_no, wr_no, dtr_no, den_no, iom_o, done_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] last_rd = 8'h00;

  always #5 clk_i = ~clk_i;

  bus_cycle_seq dut_i (
    .clk_i, .rst_ni, .req_i, .addr_i, .wr_i, .io_i, .wdata_i, .ready_i, .ad_i,
    .ad_o, .ad_oe_o, .a_hi_o, .ale_o, .rd_no, .wr_no, .dtr_no, .den_no,
    .iom_o, .rdata_o, .done_o
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_quiet(input string req);
    chk(ale_o == 0 && rd_no && wr_no && den_no && !ad_oe_o && !done_o, req,
        {ale_o, rd_no, wr_no, den_no, ad_oe_o, done_o}, 6'b011100);
  endtask

  task automatic do_cycle(input logic [19:0] a, input logic w, input logic io,
                          input logic [7:0] wd, input int waits,
                          input logic [7:0] rdev, input bit t3_low,
                          input bit hold_req);
    @(negedge clk_i);
    req_i = 1; addr_i = a; wr_i = w; io_i = io; wdata_i = wd;
    @(negedge clk_i); // T1
    chk(ale_o && ad_oe_o && ad_o == a[7:0] && a_hi_o == a[19:8], "R3",
        {ale_o, ad_oe_o, ad_o, a_hi_o}, {2'b11, a[7:0], a[19:8]});
    chk(dtr_no == w && iom_o == io && rd_no && wr_no && !done_o, "R4",
        {dtr_no, iom_o, rd_no, wr_no}, {w, io, 2'b11});
    req_i = 0;
    ready_i = t3_low ? 1'b0 : 1'b1; // R11: ignored in T1
    @(negedge clk_i); // T2
    chk(!ale_o && rd_no == w && wr_no == !w && !den_no, "R5",
        {ale_o, rd_no, wr_no, den_no}, {1'b0, w, !w, 1'b0});
    if (w) chk(ad_oe_o && ad_o == wd, "R6", {ad_oe_o, ad_o}, {1'b1, wd});
    else   chk(!ad_oe_o, "R6", ad_oe_o, 0);
    // R10: mid-cycle request and address change must be ignored
    req_i = 1; addr_i = ~a;
    ready_i = (waits == 0);
    for (int k = 0; k < waits; k++) begin
      @(negedge clk_i); // TW
      chk(!den_no && rd_no == w && wr_no == !w && !done_o && !ale_o, "R7",
          {den_no, rd_no, wr_no, done_o}, {1'b0, w, !w, 1'b0});
      ready_i = (k == waits - 1);
    end
    @(negedge clk_i); // T3
    chk(!den_no && !done_o && a_hi_o == a[19:8], "R10",
        {den_no, done_o, a_hi_o}, {2'b00, a[19:8]});
    req_i = 0; addr_i = a;
    ad_i = rdev;
    ready_i = t3_low ? 1'b0 : 1'b1; // R11: ignored in T3
    @(negedge clk_i); // T4
    chk(done_o && rd_no && wr_no && den_no && !ale_o, "R9",
        {done_o, rd_no, wr_no, den_no}, 4'b1111);
    chk(dtr_no == w && iom_o == io, "R4", {dtr_no, iom_o}, {w, io});
    if (!w) last_rd = rdev;
    chk(rdata_o == last_rd, "R8", rdata_o, last_rd);
    if (w) chk(ad_oe_o && ad_o == wd, "R6", {ad_oe_o, ad_o}, {1'b1, wd});
    ad_i = ~rdev;
    ready_i = 1'b0; // R11: ignored in T4
    req_i = hold_req;
    @(negedge clk_i); // idle or new T1
    ready_i = 1'b1;
    if (hold_req) begin
      chk(ale_o && ad_o == a[7:0], "R10", {ale_o, ad_o}, {1'b1, a[7:0]});
      req_i = 0;
    end else begin
      chk_quiet("R2");
      chk(rdata_o == last_rd, "R8", rdata_o, last_rd);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1;
    chk_quiet("R1");
    chk(dtr_no == 1, "R1", dtr_no, 1);
    repeat (4) @(negedge clk_i);
    req_i = 1; // R1: no start while reset is held
    @(negedge clk_i);
    chk_quiet("R1");
    req_i = 0;
    rst_ni = 1;
    @(negedge clk_i);
    chk_quiet("R1");

    for (int i = 0; i < NV; i++) begin
      do_cycle(VEC[i][41:22], VEC[i][21], VEC[i][20], VEC[i][19:12],
               int'(VEC[i][11:8]), VEC[i][7:0], (i % 2) == 1, 1'b0);
    end

    // R2: idle with no request stays idle
    repeat (3) @(negedge clk_i);
    chk_quiet("R2");

    // R10: back-to-back, second cycle starts right after T4
    do_cycle(20'h0BEEF, 1'b0, 1'b0, 8'h00, 0, 8'h77, 1'b0, 1'b1);
    ready_i = 1;
    @(negedge clk_i); // T2
    chk(!rd_no, "R10", rd_no, 0);
    ad_i = 8'h99;
    @(negedge clk_i); // T3
    @(negedge clk_i); // T4
    chk(done_o && rdata_o == 8'h99, "R2", {done_o, rdata_o}, {1'b1, 8'h99});
    @(negedge clk_i);
    chk_quiet("R2");

    // R1: reset in mid-cycle forces strobes inactive at once
    req_i = 1; addr_i = 20'h55555; wr_i = 1; wdata_i = 8'h11;
    @(negedge clk_i); // T1
    req_i = 0;
    @(negedge clk_i); // T2
    chk(!wr_no, "R5", wr_no, 0);
    rst_ni = 0;
    #1;
    chk_quiet("R1");
    chk(dtr_no == 1 && rdata_o == 8'h00, "R1", {dtr_no, rdata_o}, {1'b1, 8'h00});
    repeat (4) @(negedge clk_i);
    rst_ni = 1;
    repeat (2) @(negedge clk_i);
    chk_quiet("R1");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule